// File: doc/BRIEF.md
# Programmable Divider and Phase/Frequency Detector

This block sits in a frequency-synthesis loop between an already prescaled tuner oscillator signal and an analog charge pump. It counts the tuner signal down by a programmable 15-bit ratio and counts a crystal signal down by a fixed 512 to form the reference. A three-state digital phase/frequency detector compares the falling edges of the two divided signals. It requests pump-up current when the tuner edge leads and pump-down current when the reference edge leads. Each request lasts exactly as many system clocks as the two edges are apart.

Both slow inputs are sampled by the fast system clock through a two-stage synchroniser, and each rising edge advances its divider. A new tuner ratio is taken only at the divider's terminal count, so every divided period is a whole one. A tristate test control silences the pump. A routing test control replaces two general-purpose port bits with the divided reference and the divided tuner signal. A pump-current select bit passes through unchanged.

Top module: `synth_divpfd`

## Requirements
- R1: While reset is low, pump_up, pump_dn and pump_oe are 0. The tuner ratio register holds 256, and both divider counts are 0.
- R2: The tuner divider advances on each rising edge of vco_in, seen through a two-flop synchroniser, and wraps after N edges, where N = n_ratio (bit 14 MSB, valid 256 to 32767). Its level is 0 while the count is below N/2 (integer division) and 1 otherwise, so it falls at the wrap.
- R3: A new n_ratio value is loaded only when the tuner divider wraps. The period in progress always completes with the ratio it started with.
- R4: The reference divider counts synchronised rising edges of xtal_in and wraps every 512 edges. Its level is 0 for counts 0 to 255 and 1 for counts 256 to 511.
- R5: When the tuner wrap comes first, pump_up is 1 from the clock after that wrap up to and including the clock of the reference wrap. Its width equals the edge offset in system clocks.
- R6: When the reference wrap comes first, pump_dn is 1 in the same way, up to and including the clock of the tuner wrap.
- R7: Once both internal requests are set, both clear on the next clock. Wraps in the same clock produce no pulse on pump_up or pump_dn.
- R8: pump_oe is 1 exactly when pump_up or pump_dn is 1. Otherwise the pump is high-impedance.
- R9: While test_tri is 1, pump_up, pump_dn and pump_oe are 0, whatever the phase.
- R10: While test_route is 0, port_out equals port_bits. While it is 1, port_out[0] is the reference divider level and port_out[1] is the tuner divider level.
- R11: pump_hi always equals cur_hi (1 selects the high pump current).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both slow inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_in | input | 1 | Prescaled tuner oscillator signal |
| xtal_in | input | 1 | Crystal oscillator signal |
| n_ratio | input | 15 | Programmable tuner divide ratio |
| test_tri | input | 1 | Forces the pump to high-impedance |
| test_route | input | 1 | Routes the divided signals to port_out |
| cur_hi | input | 1 | High pump current select |
| port_bits | input | 2 | Normal values of the two routable port pins |
| pump_up | output | 1 | Pump-up current request |
| pump_dn | output | 1 | Pump-down current request |
| pump_oe | output | 1 | Pump drive enable (0 means high-impedance) |
| pump_hi | output | 1 | Pump current select to the charge pump |
| port_out | output | 2 | Port pin values |

## Verification
The assertions assume that n_ratio never falls below 256, so the tuner count always stays under the loaded ratio. They also assume each slow input holds every level for at least one system clock, so no edge is lost in the synchroniser. The stimulus builds both slow inputs from a free-running tick counter with periods of two to four clocks. It programs only ratios between 256 and 400, and it keeps both inputs low through reset, so every edge after reset is counted. Each sweep of the phase step starts from a fresh reset, which makes the edge offsets known in advance.

// File: rtl/synth_divpfd_pkg.sv
package synth_divpfd_pkg;
  localparam int NW        = 15;
  localparam int N_MIN     = 256;
  localparam int REF_RATIO = 512;
  localparam int SYNC_LEN  = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

  // divided level: low for the first half of the period, high after
  function automatic logic div_level(input logic [31:0] cnt, input logic [31:0] ratio);
    return cnt >= (ratio >> 1);
  endfunction

  function automatic logic at_terminal(input logic [31:0] cnt, input logic [31:0] ratio);
    return cnt == ratio - 32'd1;
  endfunction
endpackage

// File: rtl/divpfd_edge_sync.sv
module divpfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], sig_in};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/divpfd_divider.sv
module divpfd_divider
  import synth_divpfd_pkg::*;
#(
  parameter int W         = 15,
  parameter int RST_RATIO = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] ratio_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] ratio,
  output logic         wrap,
  output logic         level
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic         tc;

  assign tc = at_terminal(32'(cnt_q), 32'(ratio_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= W'(RST_RATIO);
    end else if (step) begin
      if (tc) begin
        cnt_q   <= '0;
        ratio_q <= ratio_in;   // reload only at terminal count
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wrap  = step & tc;
  assign level = div_level(32'(cnt_q), 32'(ratio_q));
  assign cnt   = cnt_q;
  assign ratio = ratio_q;
endmodule

// File: rtl/divpfd_detector.sv
module divpfd_detector
  import synth_divpfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vco_fall,
  input  logic ref_fall,
  input  logic hold_off,
  output logic up_q,
  output logic dn_q,
  output logic up,
  output logic dn,
  output logic drive
);
  pump_req_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_q.up && st_q.dn) begin
      st_q <= '0;
    end else begin
      st_q.up <= st_q.up | vco_fall;
      st_q.dn <= st_q.dn | ref_fall;
    end
  end

  assign up_q  = st_q.up;
  assign dn_q  = st_q.dn;
  assign up    = st_q.up & ~st_q.dn & ~hold_off;
  assign dn    = st_q.dn & ~st_q.up & ~hold_off;
  assign drive = up | dn;
endmodule

// File: rtl/synth_divpfd.sv
module synth_divpfd
  import synth_divpfd_pkg::*;
#(
  parameter int N_W     = NW,
  parameter int REF_DIV = REF_RATIO,
  parameter int N_RST   = N_MIN,
  parameter int SYNC    = SYNC_LEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_in,
  input  logic           xtal_in,
  input  logic [N_W-1:0] n_ratio,
  input  logic           test_tri,
  input  logic           test_route,
  input  logic           cur_hi,
  input  logic [1:0]     port_bits,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           pump_oe,
  output logic           pump_hi,
  output logic [1:0]     port_out
);
  localparam int RW = $clog2(REF_DIV) + 1;

  logic           vco_rise, ref_rise;
  logic           vco_wrap, ref_wrap;
  logic           vco_div, ref_div;
  logic [N_W-1:0] vco_cnt, vco_ratio;
  logic [RW-1:0]  ref_cnt, ref_ratio;
  logic           up_q, dn_q;
  logic [1:0]     route_src;

  divpfd_edge_sync #(.STAGES(SYNC)) vco_sync_i (
    .clk(clk), .rst_n(rst_n), .sig_in(vco_in), .rise(vco_rise)
  );

  divpfd_edge_sync #(.STAGES(SYNC)) ref_sync_i (
    .clk(clk), .rst_n(rst_n), .sig_in(xtal_in), .rise(ref_rise)
  );

  divpfd_divider #(.W(N_W), .RST_RATIO(N_RST)) vco_div_i (
    .clk(clk), .rst_n(rst_n), .step(vco_rise), .ratio_in(n_ratio),
    .cnt(vco_cnt), .ratio(vco_ratio), .wrap(vco_wrap), .level(vco_div)
  );

  divpfd_divider #(.W(RW), .RST_RATIO(REF_DIV)) ref_div_i (
    .clk(clk), .rst_n(rst_n), .step(ref_rise), .ratio_in(RW'(REF_DIV)),
    .cnt(ref_cnt), .ratio(ref_ratio), .wrap(ref_wrap), .level(ref_div)
  );

  divpfd_detector det_i (
    .clk(clk), .rst_n(rst_n), .vco_fall(vco_wrap), .ref_fall(ref_wrap),
    .hold_off(test_tri), .up_q(up_q), .dn_q(dn_q),
    .up(pump_up), .dn(pump_dn), .drive(pump_oe)
  );

  assign pump_hi   = cur_hi;
  assign route_src = {vco_div, ref_div};

  for (genvar g = 0; g < 2; g++) begin : g_port
    assign port_out[g] = test_route ? route_src[g] : port_bits[g];
  end
endmodule

// File: rtl/synth_divpfd_chk.sv
module synth_divpfd_chk #(
  parameter int N_W = 15,
  parameter int RW  = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           test_tri,
  input logic           pump_up,
  input logic           pump_dn,
  input logic           pump_oe,
  input logic           up_q,
  input logic           dn_q,
  input logic           vco_wrap,
  input logic           ref_wrap,
  input logic [N_W-1:0] vco_cnt,
  input logic [N_W-1:0] vco_ratio,
  input logic           vco_div,
  input logic [RW-1:0]  ref_cnt,
  input logic [RW-1:0]  ref_ratio
);
  // R7
  pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q));

  // R5
  up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_wrap && !up_q && !dn_q) |=> up_q);

  // R6
  dn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_wrap && !up_q && !dn_q) |=> dn_q);

  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_wrap |=> $stable(vco_ratio));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vco_cnt < vco_ratio);

  // R2
  fall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vco_wrap |=> (vco_cnt == '0 && !vco_div));

  // R4
  ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt < ref_ratio);

  // R9
  tri_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_tri |-> (!pump_up && !pump_dn && !pump_oe));
endmodule

bind synth_divpfd synth_divpfd_chk #(.N_W(N_W), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .test_tri(test_tri),
  .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
  .up_q(up_q), .dn_q(dn_q), .vco_wrap(vco_wrap), .ref_wrap(ref_wrap),
  .vco_cnt(vco_cnt), .vco_ratio(vco_ratio), .vco_div(vco_div),
  .ref_cnt(ref_cnt), .ref_ratio(ref_ratio)
);

// File: tb/synth_divpfd_tb_top.sv
module synth_divpfd_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_in = 1'b0;
  logic        xtal_in = 1'b0;
  logic [14:0] n_ratio = 15'd256;
  logic        test_tri = 1'b0;
  logic        test_route = 1'b0;
  logic        cur_hi = 1'b0;
  logic [1:0]  port_bits = 2'b00;
  logic        pump_up, pump_dn, pump_oe, pump_hi;
  logic [1:0]  port_out;

  int compared = 0;
  int mismatched = 0;
  string ptag = "R1";

  // 250 MHz: 4 time-unit period
  always #2 clk = ~clk;

  synth_divpfd dut_i (
    .clk(clk), .rst_n(rst_n), .vco_in(vco_in), .xtal_in(xtal_in),
    .n_ratio(n_ratio), .test_tri(test_tri), .test_route(test_route),
    .cur_hi(cur_hi), .port_bits(port_bits), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .pump_hi(pump_hi),
    .port_out(port_out)
  );

  // stimulus waves from a tick counter, driven away from the rising edge
  int tick = 0;
  int ph = 0;
  int vper = 4;
  always @(negedge clk) begin
    if (!rst_n) begin
      tick = 0; vco_in = 1'b0; xtal_in = 1'b0;
    end else begin
      int u;
      tick++;
      u = tick - ph - 1;
      xtal_in = (tick >= 2) && (tick % 2 == 1);
      vco_in  = (u >= 0) && ((u % vper) >= vper / 2);
    end
  end

  // behavioural reference model
  bit hv[3];
  bit hr[3];
  int mc = 0, mr = 256, rc = 0;
  bit mu = 0, md = 0;
  bit rv, rr, fv, fr;

  task automatic report(input string tag, input string fld, input int got, input int exp);
    $display("FAIL %s [%s] %s got %0d exp %0d at %0t", tag, ptag, fld, got, exp, $time);
  endtask

  task automatic compare_all();
    bit e_up, e_dn, e_oe, e_p1, e_p0;
    bit bad;
    e_up = mu && !md && !test_tri;
    e_dn = md && !mu && !test_tri;
    e_oe = e_up || e_dn;
    e_p1 = test_route ? (mc >= mr / 2) : port_bits[1];
    e_p0 = test_route ? (rc >= 256) : port_bits[0];
    bad = 0;
    compared++;
    if (pump_up !== e_up) begin bad = 1; report(test_tri ? "R9" : "R5", "pump_up", int'(pump_up), int'(e_up)); end
    if (pump_dn !== e_dn) begin bad = 1; report(test_tri ? "R9" : "R6", "pump_dn", int'(pump_dn), int'(e_dn)); end
    if (pump_oe !== e_oe) begin bad = 1; report("R8", "pump_oe", int'(pump_oe), int'(e_oe)); end
    if (pump_hi !== cur_hi) begin bad = 1; report("R11", "pump_hi", int'(pump_hi), int'(cur_hi)); end
    if (port_out[1] !== e_p1) begin bad = 1; report(test_route ? "R2" : "R10", "port_out[1]", int'(port_out[1]), int'(e_p1)); end
    if (port_out[0] !== e_p0) begin bad = 1; report(test_route ? "R4" : "R10", "port_out[0]", int'(port_out[0]), int'(e_p0)); end
    if (bad) mismatched++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hv = '{0, 0, 0}; hr = '{0, 0, 0};
      mc = 0; mr = 256; rc = 0; mu = 0; md = 0;
    end else begin
      rv = hv[1] && !hv[2];
      rr = hr[1] && !hr[2];
      hv[2] = hv[1]; hv[1] = hv[0]; hv[0] = vco_in;
      hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = xtal_in;
      fv = 0;
      if (rv) begin
        if (mc == mr - 1) begin fv = 1; mc = 0; mr = int'(n_ratio); end
        else mc++;
      end
      fr = 0;
      if (rr) begin
        if (rc == 511) begin fr = 1; rc = 0; end
        else rc++;
      end
      if (mu && md) begin mu = 0; md = 0; end
      else begin mu = mu | fv; md = md | fr; end
    end
    #1;
    if (rst_n) compare_all();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: pump quiet while in reset
    compared++;
    if (pump_up !== 1'b0 || pump_dn !== 1'b0 || pump_oe !== 1'b0 || port_out !== port_bits) begin
      mismatched++;
      $display("FAIL R1 reset outputs got up=%0b dn=%0b oe=%0b port=%0b exp 0 0 0 %0b",
               pump_up, pump_dn, pump_oe, port_out, port_bits);
    end
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(150000 * 4);
    mismatched++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    // phase sweep: equal frequencies, tuner edge offset known per step
    for (int p = 0; p < 4; p++) begin
      int ups, dns, exp_w;
      ph = p;
      n_ratio = 15'd256;
      vper = 4;
      ptag = (p == 2) ? "R7" : ((p < 2) ? "R5" : "R6");
      do_reset();
      repeat (3072) @(negedge clk);
      ups = 0; dns = 0;
      repeat (4096) begin
        @(negedge clk);
        ups += int'(pump_up);
        dns += int'(pump_dn);
      end
      exp_w = 4 * (2 - p);   // four periods of signed pulse width
      compared++;
      if (ups - dns != exp_w) begin
        mismatched++;
        $display("FAIL %s pulse width sum at phase %0d got %0d exp %0d", ptag, p, ups - dns, exp_w);
      end
    end
    // tuner faster than the reference
    ptag = "R5";
    vper = 3; n_ratio = 15'd300;
    repeat (8000) @(negedge clk);
    // ratio changes in the middle of a period
    ptag = "R3";
    n_ratio = 15'd350;
    repeat (3100) @(negedge clk);
    n_ratio = 15'd290;
    repeat (3100) @(negedge clk);
    // tuner slower than the reference
    ptag = "R6";
    n_ratio = 15'd380;
    repeat (7000) @(negedge clk);
    ptag = "R9";
    test_tri = 1'b1;
    repeat (3000) @(negedge clk);
    test_tri = 1'b0;
    ptag = "R10";
    port_bits = 2'b01;
    repeat (40) @(negedge clk);
    port_bits = 2'b10;
    test_route = 1'b1;
    repeat (4000) @(negedge clk);
    port_bits = 2'b11;
    repeat (2000) @(negedge clk);
    test_route = 1'b0;
    repeat (40) @(negedge clk);
    ptag = "R11";
    cur_hi = 1'b1;
    repeat (40) @(negedge clk);
    cur_hi = 1'b0;
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule